// File: doc/BRIEF.md
# Channel Command Word Sequencer

This block runs a channel program: a list of 64-bit command words stored in memory. A start pulse with a program address makes it fetch the first word as two 32-bit reads, the high word first. It then splits the word into command code, flags, byte count and data address, and moves bytes from a device-side byte stream into memory at successive addresses. The next word follows at the program address plus 8.

Flags on each word control the flow. A command chain flag moves on to a new command. A data chain flag keeps the current command code but takes a fresh address and count. A skip flag uses up the bytes without storing them. An interrupt flag raises a request and the program keeps running. A suspend flag holds the word until a resume pulse arrives. An indirect flag turns the data address into a pointer to a list of address words.

At the end of a program the block gives a one-cycle done pulse and a three-bit status. The parameter `CCW_FMT` selects the field layout: 1 is the layout given below, and 0 places the command code and a 24-bit address in the high word, with the flags and count in the low word. `IDA_BLK` sets how many bytes each indirect address word covers.

Top module: `ccw_sequencer`

## Requirements
- R1: After reset, `done`, `attn_irq`, `rd_req`, `dev_ready` and `wr_en` are all low.
- R2: A command word at address P is fetched as a one-cycle read at P (bits 31:24 command code, 23:16 flags, 15:0 byte count), then a one-cycle read at P+4 (bits 30:0 data address). The next command word is fetched from P+8.
- R3: Each byte accepted (`dev_ready` and `dev_valid` both high) is written to memory, starting at the data address and counting up. `dev_cmd` carries the command code. After exactly byte-count bytes, the transfer stops.
- R4: With the command-chain flag (flag bit 6) set, the next word is fetched when the count is used up, and its command code drives `dev_cmd`. No `done` pulse is given in between.
- R5: With the data-chain flag (flag bit 7) set, the next word supplies a new address and count, but its command code is ignored: `dev_cmd` keeps the earlier code.
- R6: With the skip flag (flag bit 4) set, bytes are still accepted and counted against the byte count, but nothing is written to memory.
- R7: A word with the interrupt flag (flag bit 3) gives exactly one one-cycle `attn_irq` pulse after it is fetched, and the program carries on.
- R8: A word with the suspend flag (flag bit 1) is fetched and then held: no read request and no byte transfer happen until `resume` is pulsed.
- R9: A program whose last word runs its count to zero without chaining ends with a one-cycle `done` pulse and `status` = 3'b001 (bit 2 incorrect length, bit 1 program check, bit 0 device end).
- R10: With the indirect flag (flag bit 2) set, the data address points to a list of 32-bit address words. Each list word supplies the memory address for `IDA_BLK` bytes, and the following list words are read from successive 4-byte steps.
- R11: `dev_end` ends the program after the byte that comes with it. If bytes are still left in the count, `status` is 3'b101, or 3'b001 when the suppress-length flag (flag bit 5) is set. Ending on the last byte gives 3'b001.
- R12: A word with a zero byte count and neither chain flag transfers nothing and ends the program with `status` = 3'b010. A zero count with a chain flag moves straight on to the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; ignored while a program runs |
| prog_addr | input | ADDR_W | Address of the first command word |
| resume | input | 1 | Releases a word held by the suspend flag |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data is valid |
| rd_data | input | 32 | Read data |
| dev_ready | output | 1 | Sequencer accepts a device byte this cycle |
| dev_cmd | output | 8 | Command code in force |
| dev_valid | input | 1 | Device offers a byte |
| dev_data | input | 8 | Device byte |
| dev_end | input | 1 | Device has finished the operation |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | ADDR_W | Memory byte write address |
| wr_data | output | 8 | Memory byte write data |
| attn_irq | output | 1 | Mid-program interrupt request pulse |
| done | output | 1 | Program end pulse |
| status | output | 3 | {incorrect length, program check, device end} |

## Verification
The bound checker watches, on every cycle, the properties that need only a few cycles of history. Read requests and the done and interrupt pulses last one cycle each. A write only happens on an accepted byte. The command code does not change while bytes are flowing. A program check is never reported together with device end. Addresses, counts, chaining order, the indirect list walk, the quiet interval of a suspended word and the length status all need a whole program to run. The bench shows these by sweeping byte counts, device gaps and flag combinations, and comparing memory contents against the arithmetic byte stream.

// File: rtl/ccw_pkg.sv
package ccw_pkg;

   localparam int WORD_W = 32;
   localparam int CNT_W  = 16;
   localparam int OP_W   = 8;
   localparam int FLG_W  = 8;

   // flag byte bit positions
   localparam int FL_DCH  = 7;
   localparam int FL_CCH  = 6;
   localparam int FL_SLI  = 5;
   localparam int FL_SKIP = 4;
   localparam int FL_PCI  = 3;
   localparam int FL_IDA  = 2;
   localparam int FL_SUSP = 1;

   typedef struct packed {
      logic [OP_W-1:0]   op;
      logic [FLG_W-1:0]  flg;
      logic [CNT_W-1:0]  cnt;
      logic [WORD_W-1:0] addr;
   } ccw_fields_t;

   typedef enum logic [3:0] {
      S_IDLE, S_RQ0, S_WT0, S_RQ1, S_WT1, S_DEC, S_HOLD,
      S_ARM, S_RQI, S_WTI, S_MOVE, S_NEXT
   } seq_st_t;

endpackage

// File: rtl/ccw_decode.sv
module ccw_decode
   import ccw_pkg::*;
#(
   parameter int CCW_FMT = 1
) (
   input  logic [WORD_W-1:0] w_hi,
   input  logic [WORD_W-1:0] w_lo,
   output ccw_fields_t       fld
);

   generate
      if (CCW_FMT == 1) begin : g_fmt1
         always_comb begin
            fld.op   = w_hi[31:24];
            fld.flg  = w_hi[23:16];
            fld.cnt  = w_hi[15:0];
            fld.addr = {1'b0, w_lo[30:0]};
         end
      end else begin : g_fmt0
         always_comb begin
            fld.op   = w_hi[31:24];
            fld.addr = {8'h00, w_hi[23:0]};
            fld.flg  = w_lo[31:24];
            fld.cnt  = w_lo[15:0];
         end
      end
   endgenerate

endmodule

// File: rtl/ccw_byte_engine.sv
module ccw_byte_engine #(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter int IDA_BLK = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_ld,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              ptr_ld,
   input  logic [ADDR_W-1:0] ptr_in,
   input  logic              step,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              last_byte,
   output logic              blk_last
);

   localparam int BLK_W = $clog2(IDA_BLK);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BLK_W-1:0]  blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
         blk_q  <= '0;
      end else begin
         if (cnt_ld)
            cnt_q <= cnt_in;
         else if (step)
            cnt_q <= cnt_q - CNT_W'(1);
         if (ptr_ld) begin
            addr_q <= ptr_in;
            blk_q  <= '0;
         end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
            blk_q  <= blk_q + BLK_W'(1);
         end
      end
   end

   assign cur_addr  = addr_q;
   assign last_byte = (cnt_q == CNT_W'(1));
   assign blk_last  = &blk_q;

endmodule

// File: rtl/ccw_sequencer.sv
module ccw_sequencer
   import ccw_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CCW_FMT = 1,
   parameter int IDA_BLK = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic              resume,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [WORD_W-1:0] rd_data,
   output logic              dev_ready,
   output logic [OP_W-1:0]   dev_cmd,
   input  logic              dev_valid,
   input  logic [7:0]        dev_data,
   input  logic              dev_end,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              attn_irq,
   output logic              done,
   output logic [2:0]        status
);

   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(WORD_W / 8);
   localparam logic [ADDR_W-1:0] STEP_CCW  = ADDR_W'(2 * WORD_W / 8);

   generate
      if (ADDR_W < WORD_W) begin : g_bad_aw
         $error("ccw_sequencer: ADDR_W must be at least 32");
      end
      if (IDA_BLK < 2 || (IDA_BLK & (IDA_BLK - 1)) != 0) begin : g_bad_blk
         $error("ccw_sequencer: IDA_BLK must be a power of two >= 2");
      end
      if (CCW_FMT != 0 && CCW_FMT != 1) begin : g_bad_fmt
         $error("ccw_sequencer: CCW_FMT must be 0 or 1");
      end
   endgenerate

   seq_st_t           st;
   logic [ADDR_W-1:0] pc_q, idp_q;
   logic [WORD_W-1:0] hi_q, lo_q;
   logic [OP_W-1:0]   op_q;
   logic [FLG_W-1:0]  flg_q;
   logic              dchain_q, irq_q, done_q;
   logic [2:0]        stat_q;
   ccw_fields_t       fld;
   logic [ADDR_W-1:0] cur_addr;
   logic              last_byte, blk_last, take;
   logic              cnt_ld, ptr_ld;
   logic [ADDR_W-1:0] ptr_in;

   ccw_decode #(.CCW_FMT(CCW_FMT)) u_dec (
      .w_hi (hi_q),
      .w_lo (lo_q),
      .fld  (fld)
   );

   assign take   = (st == S_MOVE) && dev_valid;
   assign cnt_ld = (st == S_ARM);
   assign ptr_ld = (st == S_ARM) || ((st == S_WTI) && rd_valid);
   assign ptr_in = (st == S_WTI) ? ADDR_W'(rd_data) : ADDR_W'(fld.addr);

   ccw_byte_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDA_BLK(IDA_BLK)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_ld    (cnt_ld),
      .cnt_in    (fld.cnt),
      .ptr_ld    (ptr_ld),
      .ptr_in    (ptr_in),
      .step      (take),
      .cur_addr  (cur_addr),
      .last_byte (last_byte),
      .blk_last  (blk_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         pc_q     <= '0;
         idp_q    <= '0;
         hi_q     <= '0;
         lo_q     <= '0;
         op_q     <= '0;
         flg_q    <= '0;
         dchain_q <= 1'b0;
         irq_q    <= 1'b0;
         done_q   <= 1'b0;
         stat_q   <= '0;
      end else begin
         irq_q  <= 1'b0;
         done_q <= 1'b0;
         unique case (st)
            S_IDLE: if (start) begin
               pc_q     <= prog_addr;
               dchain_q <= 1'b0;
               stat_q   <= '0;
               st       <= S_RQ0;
            end
            S_RQ0: st <= S_WT0;
            S_WT0: if (rd_valid) begin
               hi_q <= rd_data;
               st   <= S_RQ1;
            end
            S_RQ1: st <= S_WT1;
            S_WT1: if (rd_valid) begin
               lo_q <= rd_data;
               pc_q <= pc_q + STEP_CCW;
               st   <= S_DEC;
            end
            S_DEC: begin
               irq_q <= fld.flg[FL_PCI];
               flg_q <= fld.flg;
               if (!dchain_q) op_q <= fld.op;
               if (fld.cnt == '0 && !fld.flg[FL_DCH] && !fld.flg[FL_CCH]) begin
                  stat_q <= 3'b010;
                  done_q <= 1'b1;
                  st     <= S_IDLE;
               end else if (fld.flg[FL_SUSP]) begin
                  st <= S_HOLD;
               end else begin
                  st <= S_ARM;
               end
            end
            S_HOLD: if (resume) st <= S_ARM;
            S_ARM: begin
               if (fld.cnt == '0) begin
                  st <= S_NEXT;
               end else if (flg_q[FL_IDA]) begin
                  idp_q <= ADDR_W'(fld.addr);
                  st    <= S_RQI;
               end else begin
                  st <= S_MOVE;
               end
            end
            S_RQI: st <= S_WTI;
            S_WTI: if (rd_valid) begin
               idp_q <= idp_q + STEP_WORD;
               st    <= S_MOVE;
            end
            S_MOVE: begin
               if (take && last_byte) begin
                  st <= S_NEXT;
               end else if (dev_end) begin
                  stat_q <= {!flg_q[FL_SLI], 1'b0, 1'b1};
                  done_q <= 1'b1;
                  st     <= S_IDLE;
               end else if (take && flg_q[FL_IDA] && blk_last) begin
                  st <= S_RQI;
               end
            end
            S_NEXT: begin
               if (flg_q[FL_DCH] || flg_q[FL_CCH]) begin
                  dchain_q <= flg_q[FL_DCH];
                  st       <= S_RQ0;
               end else begin
                  stat_q <= 3'b001;
                  done_q <= 1'b1;
                  st     <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         S_RQ1:   rd_addr = pc_q + STEP_WORD;
         S_RQI:   rd_addr = idp_q;
         default: rd_addr = pc_q;
      endcase
   end

   assign rd_req    = (st == S_RQ0) || (st == S_RQ1) || (st == S_RQI);
   assign dev_ready = (st == S_MOVE);
   assign dev_cmd   = op_q;
   assign wr_en     = take && !flg_q[FL_SKIP];
   assign wr_addr   = cur_addr;
   assign wr_data   = dev_data;
   assign attn_irq  = irq_q;
   assign done      = done_q;
   assign status    = stat_q;

endmodule

// File: rtl/ccw_seq_chk.sv
module ccw_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_req,
   input logic       dev_ready,
   input logic       dev_valid,
   input logic [7:0] dev_cmd,
   input logic       wr_en,
   input logic       attn_irq,
   input logic       done,
   input logic [2:0] status
);

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req); // R2

   AST_WR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (dev_ready && dev_valid)); // R3

   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ready && $past(dev_ready)) |-> $stable(dev_cmd)); // R5

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      attn_irq |=> !attn_irq); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!dev_ready && !rd_req)); // R9

   AST_CHECK_NO_DEVEND: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status[1]) |-> !status[0]); // R12

endmodule

bind ccw_sequencer ccw_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .dev_ready (dev_ready),
   .dev_valid (dev_valid),
   .dev_cmd   (dev_cmd),
   .wr_en     (wr_en),
   .attn_irq  (attn_irq),
   .done      (done),
   .status    (status)
);

// File: tb/sim_ccw_sequencer.sv
`timescale 1ns/1ps
module sim_ccw_sequencer;

   localparam logic [7:0] F_DCH = 8'h80, F_CCH = 8'h40, F_SLI = 8'h20, F_SKIP = 8'h10;
   localparam logic [7:0] F_PCI = 8'h08, F_IDA = 8'h04, F_SUSP = 8'h02;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start = 1'b0, resume = 1'b0, clr = 1'b0;
   logic [31:0] prog_addr = '0;
   logic        rd_req, rd_valid = 1'b0;
   logic [31:0] rd_addr, rd_data = '0;
   logic        dev_ready, dev_valid = 1'b0, dev_end = 1'b0;
   logic [7:0]  dev_cmd, dev_data = '0;
   logic        wr_en, attn_irq, done;
   logic [31:0] wr_addr;
   logic [7:0]  wr_data;
   logic [2:0]  status;

   logic [31:0] wmem [0:255];
   logic [7:0]  bmem [0:1023];
   logic [31:0] rlog [0:15];
   logic [7:0]  clog [0:63];
   int nrd, nwr, bk, nirq, ndone, act;
   int end_at = -1;
   bit gap = 1'b0;
   int tick = 0;
   int nchk = 0, nfail = 0;
   logic [2:0] stat_s;

   always #2 clk = ~clk;

   ccw_sequencer #(.ADDR_W(32), .CCW_FMT(1), .IDA_BLK(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .prog_addr(prog_addr), .resume(resume),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .dev_ready(dev_ready), .dev_cmd(dev_cmd), .dev_valid(dev_valid), .dev_data(dev_data),
      .dev_end(dev_end), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .attn_irq(attn_irq), .done(done), .status(status)
   );

   // memory and monitors
   always @(posedge clk) begin
      rd_valid <= 1'b0;
      if (clr) begin
         nrd <= 0; nwr <= 0; bk <= 0; nirq <= 0; ndone <= 0; act <= 0;
         for (int i = 0; i < 1024; i++) bmem[i] <= 8'hEE;
      end else begin
         if (rd_req) begin
            rd_valid <= 1'b1;
            rd_data  <= wmem[rd_addr[9:2]];
            if (nrd < 16) rlog[nrd] <= rd_addr;
            nrd <= nrd + 1;
         end
         if (wr_en) begin
            bmem[wr_addr[9:0]] <= wr_data;
            nwr <= nwr + 1;
         end
         if (dev_ready && dev_valid) begin
            if (bk < 64) clog[bk] <= dev_cmd;
            bk <= bk + 1;
         end
         if (attn_irq) nirq <= nirq + 1;
         if (done) ndone <= ndone + 1;
         if (rd_req || dev_ready) act <= act + 1;
      end
   end

   // device model: byte k of a run is k*7+3
   always @(negedge clk) begin
      tick++;
      dev_valid = dev_ready && !(gap && tick[0]);
      dev_data  = 8'(bk * 7 + 3);
      dev_end   = dev_valid && (bk == end_at);
   end

   function automatic logic [7:0] pat(int k);
      return 8'(k * 7 + 3);
   endfunction

   task automatic chk(bit ok, string tag, int actual, int expect_v);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, actual, expect_v);
      end
   endtask

   task automatic put_ccw(int a, logic [7:0] op, logic [7:0] fl, int cnt, int da);
      wmem[a >> 2]       = {op, fl, 16'(cnt)};
      wmem[(a >> 2) + 1] = {1'b0, 31'(da)};
   endtask

   task automatic check_bytes(int base, int n, int k0, string tag);
      int bad = 0, first_act = 0, first_exp = 0;
      for (int i = 0; i < n; i++)
         if (bmem[base + i] !== pat(k0 + i)) begin
            if (bad == 0) begin first_act = int'(bmem[base + i]); first_exp = int'(pat(k0 + i)); end
            bad++;
         end
      chk(bad == 0, tag, first_act, first_exp);
   endtask

   task automatic launch(int pa);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0; prog_addr = 32'(pa); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(string tag);
      int t = 0;
      while (!done && t < 3000) begin @(negedge clk); t++; end
      if (t >= 3000) chk(1'b0, {tag, " timeout"}, 0, 1);
      stat_s = status;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) wmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!done && !attn_irq, "R1 done/irq after reset", {30'd0, done, attn_irq}, 0);
      chk(!rd_req && !dev_ready && !wr_en, "R1 ports idle after reset",
          {29'd0, rd_req, dev_ready, wr_en}, 0);

      // R2 R3 R9 sweep over counts and device gaps
      for (int g = 0; g < 2; g++) begin
         gap = g[0];
         for (int n = 1; n <= 8; n++) begin
            put_ccw(0, 8'(8'h10 + n), 8'h00, n, 'h200 + n * 8);
            launch(0); wait_done("R9 sweep");
            chk(stat_s == 3'b001, "R9 status normal end", stat_s, 1);
            chk(nwr == n, "R3 byte count", nwr, n);
            check_bytes('h200 + n * 8, n, 0, "R3 data bytes");
            chk(clog[0] == 8'(8'h10 + n), "R3 dev_cmd", clog[0], 8'h10 + n);
            chk(nrd == 2 && rlog[0] == 0 && rlog[1] == 4, "R2 fetch addresses", rlog[1], 4);
         end
      end
      gap = 1'b0;

      // R4 command chain
      put_ccw('h40, 8'hA1, F_CCH, 3, 'h300);
      put_ccw('h48, 8'hB2, 8'h00, 2, 'h320);
      launch('h40); wait_done("R4 chain");
      chk(ndone == 1 && stat_s == 3'b001, "R4 single done", ndone, 1);
      chk(clog[0] == 8'hA1 && clog[3] == 8'hB2, "R4 new command code", clog[3], 8'hB2);
      chk(rlog[2] == 'h48, "R2 next word at +8", rlog[2], 'h48);
      check_bytes('h300, 3, 0, "R4 first segment");
      check_bytes('h320, 2, 3, "R4 second segment");

      // R5 data chain
      put_ccw('h40, 8'hA1, F_DCH, 3, 'h300);
      put_ccw('h48, 8'hC3, 8'h00, 4, 'h340);
      launch('h40); wait_done("R5 data chain");
      chk(clog[3] == 8'hA1 && clog[6] == 8'hA1, "R5 code kept", clog[6], 8'hA1);
      check_bytes('h340, 4, 3, "R5 new address and count");
      chk(stat_s == 3'b001 && nwr == 7, "R5 status and bytes", nwr, 7);

      // R6 skip
      put_ccw(0, 8'h44, F_SKIP | F_CCH, 5, 'h300);
      put_ccw(8, 8'h45, 8'h00, 2, 'h340);
      launch(0); wait_done("R6 skip");
      chk(nwr == 2 && bk == 7, "R6 skipped bytes counted", bk, 7);
      chk(bmem['h300] == 8'hEE, "R6 no write while skipping", bmem['h300], 8'hEE);
      check_bytes('h340, 2, 5, "R6 bytes after skip");

      // R7 interrupt requests
      put_ccw(0, 8'h51, F_PCI | F_CCH, 2, 'h200);
      put_ccw(8, 8'h52, F_CCH, 2, 'h210);
      put_ccw(16, 8'h53, F_PCI, 2, 'h220);
      launch(0); wait_done("R7 pci");
      chk(nirq == 2, "R7 irq pulses", nirq, 2);
      chk(ndone == 1 && nwr == 6 && stat_s == 3'b001, "R7 program continues", nwr, 6);

      // R8 suspend
      put_ccw(0, 8'h61, F_SUSP, 3, 'h260);
      launch(0);
      repeat (40) @(negedge clk);
      chk(act == 2 && nwr == 0 && ndone == 0, "R8 held after fetch", act, 2);
      repeat (20) @(negedge clk);
      chk(act == 2, "R8 still held", act, 2);
      resume = 1'b1; @(negedge clk); resume = 1'b0;
      wait_done("R8 resume");
      chk(stat_s == 3'b001 && nwr == 3, "R8 runs after resume", nwr, 3);
      check_bytes('h260, 3, 0, "R8 data after resume");

      // R10 indirect addressing, 4 bytes per list word
      wmem['h80 >> 2] = 32'h380; wmem['h84 >> 2] = 32'h3A0; wmem['h88 >> 2] = 32'h3C0;
      for (int g = 0; g < 2; g++) begin
         gap = g[0];
         put_ccw(0, 8'h33, F_IDA, 10, 'h80);
         launch(0); wait_done("R10 ida");
         chk(nrd == 5 && rlog[2] == 'h80 && rlog[3] == 'h84 && rlog[4] == 'h88,
             "R10 list walk", rlog[4], 'h88);
         check_bytes('h380, 4, 0, "R10 block 0");
         check_bytes('h3A0, 4, 4, "R10 block 1");
         check_bytes('h3C0, 2, 8, "R10 block 2");
         chk(stat_s == 3'b001, "R10 status", stat_s, 1);
      end
      gap = 1'b0;

      // R11 early device end
      end_at = 3;
      put_ccw(0, 8'h71, 8'h00, 8, 'h200);
      launch(0); wait_done("R11 early");
      chk(stat_s == 3'b101 && nwr == 4, "R11 incorrect length", stat_s, 5);
      put_ccw(0, 8'h71, F_SLI, 8, 'h200);
      launch(0); wait_done("R11 sli");
      chk(stat_s == 3'b001 && nwr == 4, "R11 length masked", stat_s, 1);
      put_ccw(0, 8'h71, F_CCH, 8, 'h200);
      put_ccw(8, 8'h72, 8'h00, 2, 'h240);
      launch(0); wait_done("R11 chain stop");
      chk(nrd == 2 && stat_s == 3'b101, "R11 chain not followed", nrd, 2);
      end_at = 7;
      put_ccw(0, 8'h71, 8'h00, 8, 'h200);
      launch(0); wait_done("R11 on last");
      chk(stat_s == 3'b001 && nwr == 8, "R11 end on last byte", stat_s, 1);
      end_at = -1;

      // R12 zero count
      put_ccw(0, 8'h81, 8'h00, 0, 'h200);
      launch(0); wait_done("R12 zero");
      chk(stat_s == 3'b010, "R12 program check", stat_s, 2);
      chk(bk == 0 && nwr == 0 && nrd == 2, "R12 nothing moved", bk, 0);
      put_ccw(0, 8'h81, F_CCH, 0, 'h200);
      put_ccw(8, 8'h82, 8'h00, 3, 'h2C0);
      launch(0); wait_done("R12 zero chained");
      chk(stat_s == 3'b001 && nwr == 3 && clog[0] == 8'h82, "R12 zero count chains", nwr, 3);
      check_bytes('h2C0, 3, 0, "R12 chained data");

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule